// File: doc/BRIEF.md
# Video Line and Pixel Position Tracker

This block sits behind a video decoder that reports only three things per clock: a start-of-line event, a sample-valid strobe and a two-bit code for the current field or blanking region. The decoder gives no line or column number. The block rebuilds both from those events with two counters. It crops a configurable active window, 240 by 240 samples by default, and turns each sample inside it into a single write into a grayscale frame buffer. Only the luma byte is stored. The chroma is dropped.

The image is taken from the odd field. A start-of-line event in the blanking region that comes just before the odd field rewinds the line counter to zero. Each start-of-line event inside the odd field moves it down one line. Inside the window, the buffer address is the row offset times the window width plus the column offset. When the last sample of the window has been written, a one-cycle frame-done pulse follows. An optional second write port carries a 24-bit colour word for each written pixel, at the same address, so that a colour buffer with one entry per window pixel can be filled in parallel.

Top module: `video_pos_tracker`

## Requirements
- R1: A start-of-line event (`sol` high) sets the column counter to zero. A sample presented in the same cycle as `sol` is never written.
- R2: Every cycle with `dv` high and `sol` low advances the column counter by one. The column used for that sample is the counter value before the advance.
- R3: A start-of-line event with `region` = 2'b00 (the blanking region just before the odd field) sets the line counter to zero.
- R4: A start-of-line event with `region` = 2'b01 (odd active lines) advances the line counter by one. A start-of-line event with `region` = 2'b10 or 2'b11 leaves the line counter unchanged.
- R5: A write happens only for a valid sample whose `region` is 2'b01. Samples taken in any other region produce no write.
- R6: A valid odd-field sample at line L and column C is written when COL0 <= C < COL0+ACT_W and LINE0 <= L < LINE0+ACT_H. The write appears one cycle later on `wr_en`, with `wr_addr` = (L-LINE0)*ACT_W + (C-COL0) and `wr_data` = `luma`. Samples outside the window cause no write.
- R7: The column counter and the line counter each stop at their all-ones value rather than wrapping. Extra samples or line events therefore keep addressing the last column or line until the counter is cleared.
- R8: `frame_done` is high for one cycle, in the cycle after a write to address ACT_W*ACT_H-1, and at no other time.
- R9: With COLOR_EN set, `cwr_en`, `cwr_addr` and `cwr_data` give, in the same cycle as the grayscale write, the same address together with the 24-bit `rgb` word of that sample.
- R10: While `rst` is high, and in the first cycle after it, `wr_en`, `cwr_en` and `frame_done` are low. Both counters restart at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sol | input | 1 | Start-of-line event from the decoder |
| dv | input | 1 | Sample-valid strobe from the decoder |
| region | input | 2 | Field/blanking code: 00 pre-odd blanking, 01 odd active, 10 pre-even blanking, 11 even active |
| luma | input | LUMA_BITS | Luma byte of the current sample |
| rgb | input | COLOR_BITS | Colour word of the current sample |
| wr_en | output | 1 | Grayscale buffer write enable |
| wr_addr | output | ADDR_BITS | Grayscale buffer write address |
| wr_data | output | LUMA_BITS | Grayscale buffer write data |
| cwr_en | output | 1 | Colour buffer write enable (tied low when COLOR_EN = 0) |
| cwr_addr | output | ADDR_BITS | Colour buffer write address |
| cwr_data | output | COLOR_BITS | Colour buffer write data |
| frame_done | output | 1 | One-cycle pulse after the final window pixel is written |

## Verification
The assertions assume that `region` is held constant across a line and only changes on a start-of-line event, and that `dv` and `sol` arrive in the same cycle only when a decoder marks a line start on a sample. The stimulus applies every region change only together with `sol`. It inserts idle cycles between valid samples and issues one line start with `dv` also high. It also drives more samples per line, and more odd-field line events, than the counters can hold, so that the saturated last column and last line are written again and can be seen at the ports.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  typedef enum logic [1:0] {
    RGN_PRE_ODD  = 2'b00,
    RGN_ODD      = 2'b01,
    RGN_PRE_EVEN = 2'b10,
    RGN_EVEN     = 2'b11
  } region_e;
endpackage

// File: rtl/vpt_pixel_counter.sv
module vpt_pixel_counter #(
  parameter int PIX_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sol,
  input  logic                dv,
  output logic [PIX_BITS-1:0] pix
);
  localparam logic [PIX_BITS-1:0] PIX_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                       pix <= '0;
    else if (sol)                  pix <= '0;
    else if (dv && pix != PIX_MAX) pix <= pix + 1'b1;
  end

  assert_col_clear_R1: assert property (@(posedge clk) disable iff (rst)
    sol |=> pix == '0);
  assert_col_step_R2: assert property (@(posedge clk) disable iff (rst)
    (dv && !sol && pix != PIX_MAX) |=> pix == $past(pix) + 1'b1);
  assert_col_saturate_R7: assert property (@(posedge clk) disable iff (rst)
    (pix == PIX_MAX && !sol) |=> pix == PIX_MAX);
endmodule

// File: rtl/vpt_line_counter.sv
module vpt_line_counter #(
  parameter int LINE_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sol,
  input  vpt_pkg::region_e     region,
  output logic [LINE_BITS-1:0] line
);
  import vpt_pkg::*;
  localparam logic [LINE_BITS-1:0] LINE_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) line <= '0;
    else if (sol) begin
      if (region == RGN_PRE_ODD)                      line <= '0;
      else if (region == RGN_ODD && line != LINE_MAX) line <= line + 1'b1;
    end
  end

  assert_line_rewind_R3: assert property (@(posedge clk) disable iff (rst)
    (sol && region == RGN_PRE_ODD) |=> line == '0);
  assert_line_step_R4: assert property (@(posedge clk) disable iff (rst)
    (sol && region == RGN_ODD && line != LINE_MAX) |=> line == $past(line) + 1'b1);
  assert_line_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!sol || region == RGN_PRE_EVEN || region == RGN_EVEN) |=> $stable(line));
  assert_line_saturate_R7: assert property (@(posedge clk) disable iff (rst)
    (line == LINE_MAX && !(sol && region == RGN_PRE_ODD)) |=> line == LINE_MAX);
endmodule

// File: rtl/vpt_window_writer.sv
module vpt_window_writer #(
  parameter int ACT_W      = 240,
  parameter int ACT_H      = 240,
  parameter int COL0       = 40,
  parameter int LINE0      = 20,
  parameter int PIX_BITS   = 10,
  parameter int LINE_BITS  = 9,
  parameter int LUMA_BITS  = 8,
  parameter int COLOR_BITS = 24,
  parameter bit COLOR_EN   = 1'b1,
  localparam int ADDR_BITS = $clog2(ACT_W * ACT_H)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sol,
  input  logic                  dv,
  input  vpt_pkg::region_e      region,
  input  logic [PIX_BITS-1:0]   pix,
  input  logic [LINE_BITS-1:0]  line,
  input  logic [LUMA_BITS-1:0]  luma,
  input  logic [COLOR_BITS-1:0] rgb,
  output logic                  wr_en,
  output logic [ADDR_BITS-1:0]  wr_addr,
  output logic [LUMA_BITS-1:0]  wr_data,
  output logic                  cwr_en,
  output logic [ADDR_BITS-1:0]  cwr_addr,
  output logic [COLOR_BITS-1:0] cwr_data,
  output logic                  frame_done
);
  import vpt_pkg::*;

  localparam logic [PIX_BITS:0]    COL_LO    = (PIX_BITS+1)'(COL0);
  localparam logic [PIX_BITS:0]    COL_HI    = (PIX_BITS+1)'(COL0 + ACT_W);
  localparam logic [LINE_BITS:0]   ROW_LO    = (LINE_BITS+1)'(LINE0);
  localparam logic [LINE_BITS:0]   ROW_HI    = (LINE_BITS+1)'(LINE0 + ACT_H);
  localparam logic [ADDR_BITS-1:0] W_A       = ADDR_BITS'(ACT_W);
  localparam logic [ADDR_BITS-1:0] LAST_ADDR = ADDR_BITS'(ACT_W * ACT_H - 1);

  logic [PIX_BITS:0]    col_x;
  logic [LINE_BITS:0]   row_x;
  logic                 col_ok, row_ok, hit;
  logic [ADDR_BITS-1:0] col_a, row_a, addr_next;

  always_comb begin
    col_x     = {1'b0, pix};
    row_x     = {1'b0, line};
    col_ok    = (col_x >= COL_LO) && (col_x < COL_HI);
    row_ok    = (row_x >= ROW_LO) && (row_x < ROW_HI);
    hit       = dv && !sol && (region == RGN_ODD) && col_ok && row_ok;
    col_a     = ADDR_BITS'(col_x - COL_LO);
    row_a     = ADDR_BITS'(row_x - ROW_LO);
    addr_next = ADDR_BITS'(row_a * W_A) + col_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en      <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      wr_en      <= hit;
      frame_done <= wr_en && (wr_addr == LAST_ADDR);
    end
  end

  always_ff @(posedge clk) begin
    if (hit) begin
      wr_addr <= addr_next;
      wr_data <= luma;
    end
  end

  generate
    if (COLOR_EN) begin : g_color
      always_ff @(posedge clk) begin
        if (rst) cwr_en <= 1'b0;
        else     cwr_en <= hit;
      end
      always_ff @(posedge clk) begin
        if (hit) begin
          cwr_addr <= addr_next;
          cwr_data <= rgb;
        end
      end
      assert_color_follows_R9: assert property (@(posedge clk) disable iff (rst)
        hit |=> cwr_en && cwr_data == $past(rgb));
    end else begin : g_no_color
      logic unused_rgb;
      assign unused_rgb = ^rgb;
      assign cwr_en     = 1'b0;
      assign cwr_addr   = '0;
      assign cwr_data   = '0;
    end
  endgenerate

  assert_addr_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_addr <= LAST_ADDR);
  assert_no_write_outside_odd_R5: assert property (@(posedge clk) disable iff (rst)
    (!dv || sol || region != RGN_ODD) |=> !wr_en);
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(wr_en) && $past(wr_addr) == LAST_ADDR);
  assert_quiet_after_reset_R10: assert property (@(posedge clk)
    $past(rst) |-> !wr_en && !frame_done && !cwr_en);
endmodule

// File: rtl/video_pos_tracker.sv
module video_pos_tracker #(
  parameter int ACT_W      = 240,
  parameter int ACT_H      = 240,
  parameter int COL0       = 40,
  parameter int LINE0      = 20,
  parameter int PIX_BITS   = 10,
  parameter int LINE_BITS  = 9,
  parameter int LUMA_BITS  = 8,
  parameter int COLOR_BITS = 24,
  parameter bit COLOR_EN   = 1'b1,
  localparam int ADDR_BITS = $clog2(ACT_W * ACT_H)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sol,
  input  logic                  dv,
  input  logic [1:0]            region,
  input  logic [LUMA_BITS-1:0]  luma,
  input  logic [COLOR_BITS-1:0] rgb,
  output logic                  wr_en,
  output logic [ADDR_BITS-1:0]  wr_addr,
  output logic [LUMA_BITS-1:0]  wr_data,
  output logic                  cwr_en,
  output logic [ADDR_BITS-1:0]  cwr_addr,
  output logic [COLOR_BITS-1:0] cwr_data,
  output logic                  frame_done
);
  vpt_pkg::region_e     rgn;
  logic [PIX_BITS-1:0]  pix;
  logic [LINE_BITS-1:0] line;

  assign rgn = vpt_pkg::region_e'(region);

  vpt_pixel_counter #(.PIX_BITS(PIX_BITS)) u_pix (
    .clk(clk), .rst(rst), .sol(sol), .dv(dv), .pix(pix)
  );

  vpt_line_counter #(.LINE_BITS(LINE_BITS)) u_line (
    .clk(clk), .rst(rst), .sol(sol), .region(rgn), .line(line)
  );

  vpt_window_writer #(
    .ACT_W(ACT_W), .ACT_H(ACT_H), .COL0(COL0), .LINE0(LINE0),
    .PIX_BITS(PIX_BITS), .LINE_BITS(LINE_BITS),
    .LUMA_BITS(LUMA_BITS), .COLOR_BITS(COLOR_BITS), .COLOR_EN(COLOR_EN)
  ) u_win (
    .clk(clk), .rst(rst), .sol(sol), .dv(dv), .region(rgn),
    .pix(pix), .line(line), .luma(luma), .rgb(rgb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cwr_en(cwr_en), .cwr_addr(cwr_addr), .cwr_data(cwr_data),
    .frame_done(frame_done)
  );
endmodule

// File: tb/test_video_pos_tracker.sv
`timescale 1ns/1ps
module test_video_pos_tracker;
  localparam int W  = 6;
  localparam int H  = 5;
  localparam int C0 = 10;
  localparam int L0 = 3;
  localparam int PB = 4;
  localparam int LB = 3;
  localparam int AB = $clog2(W * H);
  localparam int PMAX = (1 << PB) - 1;
  localparam int LMAX = (1 << LB) - 1;
  localparam int LAST = W * H - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, sol, dv;
  logic [1:0] region;
  logic [7:0] luma;
  logic [23:0] rgb;
  logic wr_en, cwr_en, frame_done;
  logic [AB-1:0] wr_addr, cwr_addr;
  logic [7:0] wr_data;
  logic [23:0] cwr_data;

  video_pos_tracker #(
    .ACT_W(W), .ACT_H(H), .COL0(C0), .LINE0(L0), .PIX_BITS(PB), .LINE_BITS(LB),
    .LUMA_BITS(8), .COLOR_BITS(24), .COLOR_EN(1'b1)
  ) i_video_pos_tracker (
    .clk(clk), .rst(rst), .sol(sol), .dv(dv), .region(region), .luma(luma), .rgb(rgb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cwr_en(cwr_en), .cwr_addr(cwr_addr), .cwr_data(cwr_data), .frame_done(frame_done)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R10";
  logic [AB+32-1:0] exp_q[$];
  int m_pix = 0, m_line = 0, seed = 1;
  int exp_fd = 0, got_fd = 0;
  logic prev_last = 1'b0;
  logic mon_on = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of input and pushes the write it implies
  task automatic step(input logic s, input logic v, input logic [1:0] r);
    logic [7:0]  y;
    logic [23:0] c;
    int a;
    seed = (seed * 37 + 11) % 65521;
    y = 8'(seed);
    c = 24'(seed * 97);
    @(negedge clk);
    sol = s; dv = v; region = r; luma = y; rgb = c;
    if (s) begin
      m_pix = 0;
      if (r == 2'b00) m_line = 0;
      else if (r == 2'b01 && m_line != LMAX) m_line++;
    end else if (v) begin
      if (r == 2'b01 && m_pix >= C0 && m_pix < C0 + W && m_line >= L0 && m_line < L0 + H) begin
        a = (m_line - L0) * W + (m_pix - C0);
        exp_q.push_back({AB'(a), y, c});
        if (a == LAST) exp_fd++;
      end
      if (m_pix != PMAX) m_pix++;
    end
  endtask

  task automatic do_line(input logic [1:0] r, input int n, input logic dv_at_sol);
    step(1'b1, dv_at_sol, r);
    for (int i = 0; i < n; i++) begin
      if (i % 5 == 3) step(1'b0, 1'b0, r);
      step(1'b0, 1'b1, r);
    end
  endtask

  // monitor: compares each write against the queued expectation
  always @(negedge clk) begin
    if (mon_on) begin
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected write (R5/R6) addr", wr_addr, 0);
        end else begin
          logic [AB+32-1:0] e;
          e = exp_q.pop_front();
          check({wr_addr, wr_data, cwr_data} == e && cwr_en && cwr_addr == wr_addr,
                cur_req, "write R6/R9 {addr,luma,rgb}",
                {wr_addr, wr_data, cwr_data}, e);
        end
      end else begin
        if (cwr_en) check(1'b0, cur_req, "R9 colour write without gray write", cwr_en, 0);
      end
      if (frame_done || prev_last)
        check(frame_done == prev_last, "R8", "frame_done pulse", frame_done, prev_last);
      if (frame_done) got_fd++;
      prev_last = wr_en && (wr_addr == AB'(LAST));
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; sol = 1'b0; dv = 1'b0; region = 2'b00; luma = '0; rgb = '0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset, even with valid odd-field samples offered
    sol = 1'b0; dv = 1'b1; region = 2'b01;
    @(negedge clk);
    check(!wr_en && !cwr_en && !frame_done, "R10", "outputs during reset",
          {wr_en, cwr_en, frame_done}, 0);
    dv = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(!wr_en && !cwr_en && !frame_done, "R10", "outputs after reset",
          {wr_en, cwr_en, frame_done}, 0);
    mon_on = 1'b1;

    // R10/R2: counters start at zero; samples before any line event hit line 0
    cur_req = "R10"; step(1'b0, 1'b1, 2'b01);
    cur_req = "R3";  do_line(2'b00, 4, 1'b0);
    cur_req = "R4";
    for (int ln = 1; ln <= 4; ln++) do_line(2'b01, 16, 1'b0);
    cur_req = "R1";  do_line(2'b01, 16, 1'b1);
    cur_req = "R2";  do_line(2'b01, 16, 1'b0);
    cur_req = "R7";  do_line(2'b01, 21, 1'b0);
    cur_req = "R5";  do_line(2'b10, 16, 1'b0);
    do_line(2'b11, 16, 1'b0);
    cur_req = "R4";  step(1'b1, 1'b0, 2'b11);
    cur_req = "R7";  do_line(2'b01, 16, 1'b0);
    do_line(2'b01, 12, 1'b0);
    cur_req = "R3";  do_line(2'b00, 16, 1'b0);
    cur_req = "R6";
    for (int ln = 1; ln <= 7; ln++) do_line(2'b01, 16 + (ln % 3), 1'b0);
    cur_req = "R8";
    repeat (6) step(1'b0, 1'b0, 2'b01);

    check(exp_q.size() == 0, "R6", "missing writes", exp_q.size(), 0);
    check(got_fd == exp_fd, "R8", "frame_done count", got_fd, exp_fd);
    finish_run();
  end
endmodule